// File: doc/BRIEF.md
# Snooping Memory Write Guard

The guard sits beside the link between the system interconnect and main memory. It sees the address of every transaction on that link, whether the CPU or a DMA-capable peripheral issued it. Each write is compared against a small set of protected physical address windows. A write that lands inside any enabled window counts as a violation and raises a level interrupt to the CPU. The interrupt stays high until reset.

There are two kinds of windows. Boot windows hold the kernel-code ranges. Software loads them over a memory-mapped register port at start-up and can then lock them against all further change until the next system reset. One dynamic window covers the active page-directory entries. It can only be replaced at runtime through an authenticated report, which has two parts.

The guard publishes a one-time nonce in a readable register. A trusted reporting routine spins until that register is non-zero. It then writes the nonce back to the report register and follows it with the new page-directory address. The report is honoured only while a side input of forwarded branch targets shows that the routine is running. That evidence is an "authorised window": it opens on the routine's entry address and closes on its exit address. Any forged report is dropped and raises the interrupt. Whatever the outcome, the nonce is used up.

Top module: `snoop_wguard`

## Requirements
- R1: A snooped write (`snp_valid`=1, `snp_write`=1) whose address lies in an enabled window sets the violation status (control register word 0, bit 1), and `irq` reads 1 in the cycle after the snoop.
- R2: A window covers addresses from its base inclusive up to its bound exclusive. A write at the bound, or one below the base, raises nothing.
- R3: A window whose base equals its bound is disabled and never matches. After reset every window is disabled.
- R4: A snooped read (`snp_write`=0) never raises a violation, even inside an enabled window.
- R5: Writing 1 to bit 0 of word 0 sets the lock. Once locked, writes to word 0 and to boot window registers are ignored until reset: the lock cannot be cleared, and boot bases and bounds read back unchanged. Boot window i has its base at word 8+2i and its bound at word 9+2i.
- R6: Shortly after reset, word 1 reads a non-zero nonce.
- R7: A report is a write of the current nonce to word 2, then a write of an address A to word 2, both while the authorised window is open. It sets the dynamic window to base A (readable at word 3) and bound A+DYN_SPAN (readable at word 4), and later writes inside that window raise R1 violations.
- R8: After the second write of any report, accepted or not, word 1 reads 0 in the next cycle. One cycle later it holds a fresh non-zero value that differs from the one consumed.
- R9: A report whose first write does not equal the current nonce leaves the dynamic window unchanged. It sets the fake-report status (word 0, bit 2) and raises `irq`.
- R10: A report made without the authorised window open is rejected in the same way as R9.
- R11: The authorised window opens on a forwarded branch target equal to ENTRY_ADDR and closes on one equal to EXIT_ADDR. A report made after the close is rejected.
- R12: The lock does not block reports. A valid report is still accepted after the lock is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Snooped transaction present |
| snp_write | input | 1 | Snooped transaction is a write |
| snp_addr | input | ADDR_W | Snooped physical address |
| reg_wr | input | 1 | Register port write strobe |
| reg_addr | input | REG_AW | Register word index |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data (combinational on `reg_addr`) |
| br_valid | input | 1 | Forwarded branch target present |
| br_target | input | ADDR_W | Forwarded branch target address |
| irq | output | 1 | Sticky violation / fake-report interrupt |

## Verification
The bench builds the guard with its default parameters:
- 32-bit addresses.
- Two boot windows.
- A 16-bit nonce, which selects the 16-bit LFSR variant.
- A 4 KiB dynamic span.
- Fixed entry and exit addresses for the reporting routine.

With only two boot windows, both the boot-window compare and the dynamic-window compare are exercised from a handful of writes. The short nonce means a mismatched or stale value is a plain bit flip. Because the routine's addresses are fixed, the bench can open, close and skip the authorised window at will. It can also interleave the lock with a report, so lock blocking and report acceptance are checked independently.

// File: rtl/sw_pkg.sv
package sw_pkg;

   // Register word indices; boot windows start at SW_BOOT0 and use two words each.
   localparam int unsigned SW_CTRL   = 0;
   localparam int unsigned SW_NONCE  = 1;
   localparam int unsigned SW_REPORT = 2;
   localparam int unsigned SW_DYN_LO = 3;
   localparam int unsigned SW_DYN_HI = 4;
   localparam int unsigned SW_BOOT0  = 8;

   // Control word bit positions.
   localparam int unsigned SW_B_LOCK = 0;
   localparam int unsigned SW_B_VIOL = 1;
   localparam int unsigned SW_B_FAKE = 2;

   typedef enum logic {
      RPT_NONCE = 1'b0,
      RPT_ADDR  = 1'b1
   } rpt_phase_e;

endpackage

// File: rtl/sw_range_cmp.sv
module sw_range_cmp #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] bound,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   logic enabled;
   logic above_base;
   logic below_bound;

   always_comb begin
      enabled     = (base != bound);
      above_base  = (addr >= base);
      below_bound = (addr < bound);
      hit         = enabled && above_base && below_bound;
   end
endmodule

// File: rtl/sw_nonce_gen.sv
module sw_nonce_gen #(
   parameter int unsigned NONCE_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               consume,
   output logic [NONCE_W-1:0] nonce
);
   localparam logic [NONCE_W-1:0] SEED = NONCE_W'(1);

   logic [NONCE_W-1:0] taps;
   logic [NONCE_W-1:0] lfsr_q;
   logic [NONCE_W-1:0] lfsr_d;
   logic [NONCE_W-1:0] nonce_q;

   generate
      if (NONCE_W == 16) begin : g_taps16
         assign taps = NONCE_W'(32'h0000_B400);
      end else if (NONCE_W == 32) begin : g_taps32
         assign taps = NONCE_W'(32'h8020_0003);
      end else begin : g_taps_bad
         $error("sw_nonce_gen: NONCE_W must be 16 or 32");
         assign taps = '0;
      end
   endgenerate

   always_comb begin
      lfsr_d = lfsr_q >> 1;
      if (lfsr_q[0]) lfsr_d = lfsr_d ^ taps;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lfsr_q  <= SEED;
         nonce_q <= '0;
      end else begin
         lfsr_q <= lfsr_d;
         if (consume) begin
            nonce_q <= '0;
         end else if (nonce_q == '0) begin
            nonce_q <= lfsr_q;
         end
      end
   end

   assign nonce = nonce_q;
endmodule

// File: rtl/sw_auth_window.sv
module sw_auth_window #(
   parameter int unsigned        ADDR_W     = 32,
   parameter logic [ADDR_W-1:0]  ENTRY_ADDR = '0,
   parameter logic [ADDR_W-1:0]  EXIT_ADDR  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              br_valid,
   input  logic [ADDR_W-1:0] br_target,
   output logic              open
);
   logic open_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
      end else if (br_valid) begin
         if (br_target == ENTRY_ADDR) begin
            open_q <= 1'b1;
         end else if (br_target == EXIT_ADDR) begin
            open_q <= 1'b0;
         end
      end
   end

   assign open = open_q;
endmodule

// File: rtl/snoop_wguard.sv
module snoop_wguard #(
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       REG_AW     = 5,
   parameter int unsigned       N_BOOT     = 2,
   parameter int unsigned       NONCE_W    = 16,
   parameter int unsigned       DYN_SPAN   = 32'h0000_1000,
   parameter logic [ADDR_W-1:0] ENTRY_ADDR = 32'hC000_8000,
   parameter logic [ADDR_W-1:0] EXIT_ADDR  = 32'hC000_8040
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snp_valid,
   input  logic              snp_write,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              br_valid,
   input  logic [ADDR_W-1:0] br_target,
   output logic              irq
);
   import sw_pkg::*;

   localparam int unsigned N_RNG  = N_BOOT + 1;
   localparam int unsigned DYN_IX = N_BOOT;
   localparam int unsigned TOP_WD = SW_BOOT0 + 2 * N_BOOT;

   generate
      if (N_BOOT < 1) begin : g_chk_boot
         $error("snoop_wguard: N_BOOT must be at least 1");
      end
      if (TOP_WD > (1 << REG_AW)) begin : g_chk_aw
         $error("snoop_wguard: REG_AW too narrow for the boot windows");
      end
      if (NONCE_W > ADDR_W) begin : g_chk_nw
         $error("snoop_wguard: NONCE_W must not exceed ADDR_W");
      end
   endgenerate

   // Configuration and status state.
   logic              locked_q;
   logic              viol_q;
   logic              fake_q;
   logic [ADDR_W-1:0] boot_base_q  [N_BOOT];
   logic [ADDR_W-1:0] boot_bound_q [N_BOOT];
   logic [ADDR_W-1:0] dyn_base_q;
   logic [ADDR_W-1:0] dyn_bound_q;
   logic [2*N_BOOT*ADDR_W-1:0] boot_flat;

   // Report exchange.
   rpt_phase_e        phase_q;
   logic              rpt_ok_q;
   logic              rpt_wr;
   logic              rpt_commit;
   logic              rpt_accept;
   logic              nonce_match;
   logic [NONCE_W-1:0] nonce;
   logic              win_open;

   // Range comparison.
   logic [ADDR_W-1:0] rng_base  [N_RNG];
   logic [ADDR_W-1:0] rng_bound [N_RNG];
   logic [N_RNG-1:0]  rng_hit;
   logic              hit_any;
   logic              wr_hit;

   sw_auth_window #(
      .ADDR_W    (ADDR_W),
      .ENTRY_ADDR(ENTRY_ADDR),
      .EXIT_ADDR (EXIT_ADDR)
   ) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .br_valid (br_valid),
      .br_target(br_target),
      .open     (win_open)
   );

   sw_nonce_gen #(
      .NONCE_W(NONCE_W)
   ) u_nonce (
      .clk    (clk),
      .rst_n  (rst_n),
      .consume(rpt_commit),
      .nonce  (nonce)
   );

   genvar gi;
   generate
      for (gi = 0; gi < N_BOOT; gi++) begin : g_boot
         assign rng_base[gi]  = boot_base_q[gi];
         assign rng_bound[gi] = boot_bound_q[gi];
         assign boot_flat[(2*gi)*ADDR_W   +: ADDR_W] = boot_base_q[gi];
         assign boot_flat[(2*gi+1)*ADDR_W +: ADDR_W] = boot_bound_q[gi];
      end
      assign rng_base[DYN_IX]  = dyn_base_q;
      assign rng_bound[DYN_IX] = dyn_bound_q;

      for (gi = 0; gi < N_RNG; gi++) begin : g_cmp
         sw_range_cmp #(
            .ADDR_W(ADDR_W)
         ) u_cmp (
            .base (rng_base[gi]),
            .bound(rng_bound[gi]),
            .addr (snp_addr),
            .hit  (rng_hit[gi])
         );
      end
   endgenerate

   always_comb begin
      hit_any     = |rng_hit;
      wr_hit      = snp_valid && snp_write && hit_any;
      rpt_wr      = reg_wr && (reg_addr == REG_AW'(SW_REPORT));
      rpt_commit  = rpt_wr && (phase_q == RPT_ADDR);
      rpt_accept  = rpt_commit && rpt_ok_q && win_open;
      nonce_match = (reg_wdata == ADDR_W'(nonce)) && (nonce != '0);
   end

   // Configuration writes, blocked once locked.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         for (int i = 0; i < N_BOOT; i++) begin
            boot_base_q[i]  <= '0;
            boot_bound_q[i] <= '0;
         end
      end else if (reg_wr && !locked_q) begin
         if ((reg_addr == REG_AW'(SW_CTRL)) && reg_wdata[SW_B_LOCK]) begin
            locked_q <= 1'b1;
         end
         for (int i = 0; i < N_BOOT; i++) begin
            if (reg_addr == REG_AW'(SW_BOOT0 + 2 * i)) begin
               boot_base_q[i] <= reg_wdata;
            end
            if (reg_addr == REG_AW'(SW_BOOT0 + 2 * i + 1)) begin
               boot_bound_q[i] <= reg_wdata;
            end
         end
      end
   end

   // Report exchange: nonce write, then address write.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q     <= RPT_NONCE;
         rpt_ok_q    <= 1'b0;
         dyn_base_q  <= '0;
         dyn_bound_q <= '0;
      end else if (rpt_wr) begin
         if (phase_q == RPT_NONCE) begin
            rpt_ok_q <= nonce_match && win_open;
            phase_q  <= RPT_ADDR;
         end else begin
            rpt_ok_q <= 1'b0;
            phase_q  <= RPT_NONCE;
            if (rpt_accept) begin
               dyn_base_q  <= reg_wdata;
               dyn_bound_q <= reg_wdata + ADDR_W'(DYN_SPAN);
            end
         end
      end
   end

   // Sticky status.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         viol_q <= 1'b0;
         fake_q <= 1'b0;
      end else begin
         if (wr_hit) viol_q <= 1'b1;
         if (rpt_commit && !rpt_accept) fake_q <= 1'b1;
      end
   end

   assign irq = viol_q | fake_q;

   // Read mux.
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == REG_AW'(SW_CTRL)) begin
         reg_rdata[SW_B_LOCK] = locked_q;
         reg_rdata[SW_B_VIOL] = viol_q;
         reg_rdata[SW_B_FAKE] = fake_q;
      end else if (reg_addr == REG_AW'(SW_NONCE)) begin
         reg_rdata = ADDR_W'(nonce);
      end else if (reg_addr == REG_AW'(SW_DYN_LO)) begin
         reg_rdata = dyn_base_q;
      end else if (reg_addr == REG_AW'(SW_DYN_HI)) begin
         reg_rdata = dyn_bound_q;
      end
      for (int i = 0; i < N_BOOT; i++) begin
         if (reg_addr == REG_AW'(SW_BOOT0 + 2 * i))     reg_rdata = boot_base_q[i];
         if (reg_addr == REG_AW'(SW_BOOT0 + 2 * i + 1)) reg_rdata = boot_bound_q[i];
      end
   end
endmodule

// File: rtl/sw_checker.sv
module sw_checker #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned N_BOOT  = 2,
   parameter int unsigned NONCE_W = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       snp_valid,
   input logic                       snp_write,
   input logic                       hit_any,
   input logic                       irq,
   input logic                       locked_q,
   input logic [2*N_BOOT*ADDR_W-1:0] boot_flat,
   input logic                       win_open,
   input logic [ADDR_W-1:0]          dyn_base_q,
   input logic                       rpt_commit,
   input logic [NONCE_W-1:0]         nonce
);
   a_r1_write_hit_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_write && hit_any) |=> irq);

   a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> irq);

   a_r5_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> locked_q);

   a_r5_boot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> $stable(boot_flat));

   a_r11_dyn_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
      !win_open |=> $stable(dyn_base_q));

   a_r8_nonce_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_commit |=> (nonce == '0));
endmodule

bind snoop_wguard sw_checker #(
   .ADDR_W (ADDR_W),
   .N_BOOT (N_BOOT),
   .NONCE_W(NONCE_W)
) u_sw_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .snp_valid (snp_valid),
   .snp_write (snp_write),
   .hit_any   (hit_any),
   .irq       (irq),
   .locked_q  (locked_q),
   .boot_flat (boot_flat),
   .win_open  (win_open),
   .dyn_base_q(dyn_base_q),
   .rpt_commit(rpt_commit),
   .nonce     (nonce)
);

// File: tb/test_snoop_wguard.sv
`timescale 1ns/1ps
module test_snoop_wguard;
   localparam int unsigned ADDR_W = 32;
   localparam int unsigned REG_AW = 5;
   localparam logic [31:0] ENTRY  = 32'hC000_8000;
   localparam logic [31:0] EXITA  = 32'hC000_8040;
   localparam logic [31:0] SPAN   = 32'h0000_1000;
   localparam int unsigned W_CTRL = 0, W_NONCE = 1, W_RPT = 2, W_DLO = 3, W_DHI = 4;
   localparam int unsigned W_B0 = 8, W_E0 = 9;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              snp_valid = 1'b0;
   logic              snp_write = 1'b0;
   logic [ADDR_W-1:0] snp_addr = '0;
   logic              reg_wr = 1'b0;
   logic [REG_AW-1:0] reg_addr = '0;
   logic [ADDR_W-1:0] reg_wdata = '0;
   logic [ADDR_W-1:0] reg_rdata;
   logic              br_valid = 1'b0;
   logic [ADDR_W-1:0] br_target = '0;
   logic              irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   snoop_wguard i_snoop_wguard (
      .clk(clk), .rst_n(rst_n),
      .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .br_valid(br_valid), .br_target(br_target), .irq(irq)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      snp_valid = 1'b0; reg_wr = 1'b0; br_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic reg_write(input int unsigned a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = REG_AW'(a); reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input int unsigned a, output logic [31:0] d);
      reg_addr = REG_AW'(a);
      #0.5;
      d = reg_rdata;
   endtask

   task automatic snoop(input logic [31:0] a, input bit wr);
      @(negedge clk);
      snp_valid = 1'b1; snp_write = wr; snp_addr = a;
      @(negedge clk);
      snp_valid = 1'b0;
   endtask

   task automatic branch(input logic [31:0] t);
      @(negedge clk);
      br_valid = 1'b1; br_target = t;
      @(negedge clk);
      br_valid = 1'b0;
   endtask

   task automatic get_nonce(output logic [31:0] n);
      n = '0;
      for (int k = 0; k < 8 && n == '0; k++) begin
         @(negedge clk);
         reg_read(W_NONCE, n);
      end
   endtask

   task automatic boot_cfg();
      reg_write(W_B0, 32'h0000_1000);
      reg_write(W_E0, 32'h0000_2000);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      do_reset();
      check(irq == 1'b0, "R1 irq low after reset", 32'(irq), 0);
      reg_read(W_CTRL, d);
      check(d == 0, "R5 ctrl clear after reset", d, 0);
      repeat (2) @(negedge clk);
      reg_read(W_NONCE, d);
      check(d != 0, "R6 nonce non-zero after reset", d, 1);
   endtask

   task automatic t_boot_hit();
      logic [31:0] d;
      do_reset(); boot_cfg();
      snoop(32'h0000_1800, 1'b1);
      check(irq == 1'b1, "R1 write in boot window", 32'(irq), 1);
      reg_read(W_CTRL, d);
      check(d[1] == 1'b1, "R1 violation status bit", d, 32'h2);
   endtask

   task automatic t_edges();
      do_reset(); boot_cfg();
      snoop(32'h0000_2000, 1'b1);
      check(irq == 1'b0, "R2 write at bound", 32'(irq), 0);
      snoop(32'h0000_0FFF, 1'b1);
      check(irq == 1'b0, "R2 write below base", 32'(irq), 0);
      snoop(32'h0000_1000, 1'b1);
      check(irq == 1'b1, "R2 write at base", 32'(irq), 1);
   endtask

   task automatic t_disabled();
      do_reset();
      snoop(32'h0000_0000, 1'b1);
      check(irq == 1'b0, "R3 all windows disabled after reset", 32'(irq), 0);
      reg_write(W_B0, 32'h0000_3000);
      reg_write(W_E0, 32'h0000_3000);
      snoop(32'h0000_3000, 1'b1);
      check(irq == 1'b0, "R3 base equals bound", 32'(irq), 0);
   endtask

   task automatic t_read();
      do_reset(); boot_cfg();
      snoop(32'h0000_1800, 1'b0);
      check(irq == 1'b0, "R4 read in window", 32'(irq), 0);
   endtask

   task automatic t_lock();
      logic [31:0] d;
      do_reset(); boot_cfg();
      reg_write(W_CTRL, 32'h1);
      reg_write(W_B0, 32'h0000_5000);
      reg_write(W_E0, 32'h0000_6000);
      reg_read(W_B0, d);
      check(d == 32'h0000_1000, "R5 boot base frozen", d, 32'h0000_1000);
      reg_read(W_E0, d);
      check(d == 32'h0000_2000, "R5 boot bound frozen", d, 32'h0000_2000);
      reg_write(W_CTRL, 32'h0);
      reg_read(W_CTRL, d);
      check(d[0] == 1'b1, "R5 lock cannot clear", d, 1);
      snoop(32'h0000_5800, 1'b1);
      check(irq == 1'b0, "R5 ignored window not active", 32'(irq), 0);
   endtask

   task automatic good_report(input logic [31:0] a, output logic [31:0] used);
      branch(ENTRY);
      get_nonce(used);
      reg_write(W_RPT, used);
      reg_write(W_RPT, a);
   endtask

   task automatic t_report();
      logic [31:0] n, d, n2;
      do_reset();
      good_report(32'h0004_0000, n);
      reg_read(W_NONCE, d);
      check(d == 0, "R8 nonce cleared after report", d, 0);
      @(negedge clk);
      reg_read(W_NONCE, n2);
      check(n2 != 0 && n2 != n, "R8 fresh nonce", n2, n);
      reg_read(W_DLO, d);
      check(d == 32'h0004_0000, "R7 dynamic base", d, 32'h0004_0000);
      reg_read(W_DHI, d);
      check(d == 32'h0004_0000 + SPAN, "R7 dynamic bound", d, 32'h0004_0000 + SPAN);
      check(irq == 1'b0, "R7 accepted report no irq", 32'(irq), 0);
      snoop(32'h0004_0010, 1'b1);
      check(irq == 1'b1, "R7 write in dynamic window", 32'(irq), 1);
   endtask

   task automatic t_bad_nonce();
      logic [31:0] n, d;
      do_reset();
      branch(ENTRY);
      get_nonce(n);
      reg_write(W_RPT, n ^ 32'h1);
      reg_write(W_RPT, 32'h0004_0000);
      reg_read(W_DLO, d);
      check(d == 0, "R9 dynamic base unchanged", d, 0);
      reg_read(W_CTRL, d);
      check(d[2] == 1'b1, "R9 fake status", d, 32'h4);
      check(irq == 1'b1, "R9 irq on fake report", 32'(irq), 1);
      reg_read(W_NONCE, d);
      check(d == 0, "R8 nonce cleared after rejected report", d, 0);
   endtask

   task automatic t_no_window();
      logic [31:0] n, d;
      do_reset();
      get_nonce(n);
      reg_write(W_RPT, n);
      reg_write(W_RPT, 32'h0004_0000);
      reg_read(W_DLO, d);
      check(d == 0, "R10 report without window rejected", d, 0);
      check(irq == 1'b1, "R10 irq", 32'(irq), 1);
   endtask

   task automatic t_closed();
      logic [31:0] n, d;
      do_reset();
      branch(ENTRY);
      branch(32'hC000_8010);
      branch(EXITA);
      get_nonce(n);
      reg_write(W_RPT, n);
      reg_write(W_RPT, 32'h0004_0000);
      reg_read(W_DLO, d);
      check(d == 0, "R11 report after exit rejected", d, 0);
      reg_read(W_CTRL, d);
      check(d[2] == 1'b1, "R11 fake status", d, 32'h4);
   endtask

   task automatic t_locked_report();
      logic [31:0] n, d;
      do_reset(); boot_cfg();
      reg_write(W_CTRL, 32'h1);
      good_report(32'h0008_0000, n);
      reg_read(W_DLO, d);
      check(d == 32'h0008_0000, "R12 report accepted while locked", d, 32'h0008_0000);
      check(irq == 1'b0, "R12 no fake report", 32'(irq), 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_boot_hit();
      t_edges();
      t_disabled();
      t_read();
      t_lock();
      t_report();
      t_bad_nonce();
      t_no_window();
      t_closed();
      t_locked_report();
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end
endmodule